// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a simple host request port and an asynchronous 4M x 4 page-mode DRAM. Each host request carries a 22-bit word address, a write flag and a 4-bit data nibble. The block drives the row strobe, column strobe, write enable and output enable, all active low. It time-multiplexes the upper and lower address halves onto one shared 11-bit address bus. It returns read nibbles with a one-cycle valid pulse. All electrical timing minimums and maximums are module parameters counted in whole clock cycles.

After an access the row stays open. A later request to the same row costs only a column cycle. A request to a different row, an asserted refresh grant, or the approach of the longest legal row-active time closes the row. The next activation then waits out the full precharge time. The refresh grant input lets an outside arbiter take the DRAM bus. While the grant is high, the block accepts nothing and leaves the row strobe high once any access in flight has ended.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, all four strobes are high (inactive), the data driver is off and rd_valid is low.
- R2: The row is req_addr[21:11] and the column is req_addr[10:0]. The row is on dram_addr when the row strobe falls and stays there for T_RAH low cycles. The column is on dram_addr when the column strobe falls.
- R3: A read returns the nibble on dram_dq_in sampled at the edge where the column strobe rises. That edge comes after at least max(T_CAS,T_CAC) column-low cycles and at least T_RAC row-low cycles. rd_valid is a one-cycle pulse that coincides with rd_data.
- R4: For a write, write enable goes low at least one cycle before the column strobe falls and stays low while it is low. The write nibble is driven (dram_dq_oe=1) over the same span, and output enable stays high.
- R5: Consecutive accesses to the open row do not raise the row strobe; only column cycles are issued.
- R6: A request to another row closes the open row. The row strobe then stays high for at least T_RP cycles before it falls again.
- R7: Each row-low interval lasts at least max(T_RAS_MIN, T_RC-T_RP) cycles.
- R8: The row strobe is never low for more than T_RAS_MAX cycles. The row closes on its own near that limit, even under a stream of row hits or with no traffic.
- R9: Between column accesses the column strobe stays high for at least T_CP cycles. Successive column-strobe falls are at least T_PC cycles apart.
- R10: While ref_grant is high, req_ready is low. An open row is closed after the access in flight, and the row strobe does not fall.
- R11: The column strobe falls no sooner than T_RCD cycles after the row strobe falls.
- R12: The column strobe is low only while the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | 22 | Word address, row in upper half |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write nibble |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 4 | Read nibble |
| ref_grant | input | 1 | External refresh owns the DRAM bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Write data toward the pads |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Read data from the pads |

## Verification
A stale open-row register shows up at once as a missing or extra row-strobe fall. The DRAM model also sees a wrong row latched at the next column strobe. A phase counter that restarts late or early shows within one interval as a strobe width or spacing below its minimum. A read sampled too soon returns the model's inverted stale nibble, so rd_data mismatches on that same pulse. A missed row-age limit shows as a row-low interval that outruns T_RAS_MAX, caught at the first cycle beyond it.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // row closed, precharging or waiting
    ST_ROW,    // row address on bus, row strobe about to fall
    ST_RCD,    // row strobe low, row address held
    ST_CSU,    // column address and write controls set up
    ST_CAS,    // column strobe low
    ST_OPEN    // row open, column strobe high
  } fpm_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_age_cnt.sv
// Counts the cycles a strobe has spent in its present phase, the current
// cycle included. A clear marks the edge that starts a new phase.
module fpm_age_cnt #(
  parameter int W   = 8,
  parameter int MAX = 200
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] age
);
  localparam logic [W-1:0] SAT = W'(MAX);

  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (clr)        age <= W'(1);
    else if (age != SAT) age <= age + 1'b1;
  end
endmodule

// File: rtl/fpm_row_track.sv
// Holds the row that is currently open and compares it with a probe row.
module fpm_row_track #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic [ROW_W-1:0] probe_row_i,
  output logic             hit_o
);
  logic             valid_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      row_q   <= '0;
    end else if (open_i) begin
      valid_q <= 1'b1;
      row_q   <= open_row_i;
    end else if (close_i) begin
      valid_q <= 1'b0;
    end
  end

  assign hit_o = valid_q && (row_q == probe_row_i);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 11,
  parameter int DQ_W      = 4,
  parameter int T_RP      = 5,
  parameter int T_RC      = 14,
  parameter int T_RAS_MIN = 8,
  parameter int T_RAH     = 2,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 2,
  parameter int T_CAC     = 2,
  parameter int T_RAC     = 8,
  parameter int T_CP      = 2,
  parameter int T_PC      = 5,
  parameter int T_RAS_MAX = 12500
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [ROW_W+COL_W-1:0]               req_addr,
  input  logic                                 req_write,
  input  logic [DQ_W-1:0]                      req_wdata,
  output logic                                 rd_valid,
  output logic [DQ_W-1:0]                      rd_data,
  input  logic                                 ref_grant,
  output logic                                 dram_ras_n,
  output logic                                 dram_cas_n,
  output logic                                 dram_we_n,
  output logic                                 dram_oe_n,
  output logic [fpm_pkg::imax(ROW_W,COL_W)-1:0] dram_addr,
  output logic [DQ_W-1:0]                      dram_dq_out,
  output logic                                 dram_dq_oe,
  input  logic [DQ_W-1:0]                      dram_dq_in
);
  import fpm_pkg::*;

  localparam int ADDR_W    = ROW_W + COL_W;
  localparam int PIN_W     = imax(ROW_W, COL_W);
  localparam int T_RAS_EFF = imax(T_RAS_MIN, T_RC - T_RP);
  localparam int T_CAS_RD  = imax(T_CAS, T_CAC);
  localparam int ACC_WORST = T_PC + T_CP + T_CAS_RD + 3;
  localparam int RAS_LIMIT = T_RAS_MAX - ACC_WORST;
  localparam int CNT_MAX   = imax(T_RAS_MAX, imax(T_RC, imax(T_PC, T_RAC)));
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int N_AGE     = 3;
  localparam int A_RAS     = 0;  // phase age of the row strobe
  localparam int A_CAS     = 1;  // phase age of the column strobe
  localparam int A_CASF    = 2;  // cycles since the last column-strobe fall

  localparam logic [CNT_W-1:0] L_RP    = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] L_RAH   = CNT_W'(T_RAH);
  localparam logic [CNT_W-1:0] L_RCD   = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] L_CAS   = CNT_W'(T_CAS);
  localparam logic [CNT_W-1:0] L_CASRD = CNT_W'(T_CAS_RD);
  localparam logic [CNT_W-1:0] L_RAC   = CNT_W'(T_RAC);
  localparam logic [CNT_W-1:0] L_CP    = CNT_W'(T_CP);
  localparam logic [CNT_W-1:0] L_PC    = CNT_W'(T_PC);
  localparam logic [CNT_W-1:0] L_EFF   = CNT_W'(T_RAS_EFF);
  localparam logic [CNT_W-1:0] L_LIMIT = CNT_W'(RAS_LIMIT);

  // registered state and pins
  fpm_state_e       st_q, n_st;
  logic             ras_q, cas_q, we_q, oe_q, dqoe_q;
  logic             n_ras, n_cas, n_we, n_oe, n_dqoe;
  logic [PIN_W-1:0] addr_q, n_addr;
  logic [DQ_W-1:0]  dq_q, n_dq;
  logic             rdv_q;
  logic [DQ_W-1:0]  rdd_q;
  logic             wr_q, n_wr;
  logic [COL_W-1:0] col_q, n_col;
  logic [DQ_W-1:0]  wd_q, n_wd;

  logic             cap, row_open, row_close, hit;
  logic [N_AGE-1:0] age_clr;
  logic [CNT_W-1:0] age_q [N_AGE];
  logic [CNT_W-1:0] ras_age, cas_age, casf_age;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  assign req_row = req_addr[ADDR_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  assign age_clr[A_RAS]  = (n_ras != ras_q);
  assign age_clr[A_CAS]  = (n_cas != cas_q);
  assign age_clr[A_CASF] = cas_q && !n_cas;

  generate
    for (genvar gi = 0; gi < N_AGE; gi++) begin : g_age
      fpm_age_cnt #(.W(CNT_W), .MAX(CNT_MAX)) u_age (
        .clk (clk),
        .rst (rst),
        .clr (age_clr[gi]),
        .age (age_q[gi])
      );
    end
  endgenerate

  assign ras_age  = age_q[A_RAS];
  assign cas_age  = age_q[A_CAS];
  assign casf_age = age_q[A_CASF];

  fpm_row_track #(.ROW_W(ROW_W)) u_row (
    .clk         (clk),
    .rst         (rst),
    .open_i      (row_open),
    .close_i     (row_close),
    .open_row_i  (req_row),
    .probe_row_i (req_row),
    .hit_o       (hit)
  );

  always_comb begin
    n_st      = st_q;
    n_ras     = ras_q;
    n_cas     = cas_q;
    n_we      = we_q;
    n_oe      = oe_q;
    n_dqoe    = dqoe_q;
    n_addr    = addr_q;
    n_dq      = dq_q;
    n_wr      = wr_q;
    n_col     = col_q;
    n_wd      = wd_q;
    req_ready = 1'b0;
    cap       = 1'b0;
    row_open  = 1'b0;
    row_close = 1'b0;
    case (st_q)
      ST_IDLE: begin
        req_ready = !ref_grant;
        if (req_valid && !ref_grant) begin
          n_addr   = PIN_W'(req_row);
          n_wr     = req_write;
          n_col    = req_col;
          n_wd     = req_wdata;
          row_open = 1'b1;
          n_st     = ST_ROW;
        end
      end
      ST_ROW: begin
        if (ras_age >= L_RP && !ref_grant) begin
          n_ras = 1'b0;
          n_st  = ST_RCD;
        end
      end
      ST_RCD: begin
        if (ras_age >= L_RAH) begin
          n_addr = PIN_W'(col_q);
          n_we   = !wr_q;
          n_dqoe = wr_q;
          n_dq   = wd_q;
          n_st   = ST_CSU;
        end
      end
      ST_CSU: begin
        if (ras_age >= L_RCD && cas_age >= L_CP && casf_age >= L_PC) begin
          n_cas = 1'b0;
          n_oe  = wr_q;
          n_st  = ST_CAS;
        end
      end
      ST_CAS: begin
        if (wr_q) begin
          if (cas_age >= L_CAS) begin
            n_cas  = 1'b1;
            n_we   = 1'b1;
            n_dqoe = 1'b0;
            n_st   = ST_OPEN;
          end
        end else if (cas_age >= L_CASRD && ras_age >= L_RAC) begin
          n_cas = 1'b1;
          n_oe  = 1'b1;
          cap   = 1'b1;
          n_st  = ST_OPEN;
        end
      end
      ST_OPEN: begin
        req_ready = hit && !ref_grant && (ras_age < L_LIMIT);
        if (req_valid && req_ready) begin
          n_addr = PIN_W'(req_col);
          n_wr   = req_write;
          n_col  = req_col;
          n_wd   = req_wdata;
          n_we   = !req_write;
          n_dqoe = req_write;
          n_dq   = req_wdata;
          n_st   = ST_CSU;
        end else if (ras_age >= L_EFF &&
                     (ras_age >= L_LIMIT || ref_grant || (req_valid && !hit))) begin
          n_ras     = 1'b1;
          row_close = 1'b1;
          n_st      = ST_IDLE;
        end
      end
      default: n_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      dqoe_q <= 1'b0;
      addr_q <= '0;
      dq_q   <= '0;
      rdv_q  <= 1'b0;
      rdd_q  <= '0;
      wr_q   <= 1'b0;
      col_q  <= '0;
      wd_q   <= '0;
    end else begin
      st_q   <= n_st;
      ras_q  <= n_ras;
      cas_q  <= n_cas;
      we_q   <= n_we;
      oe_q   <= n_oe;
      dqoe_q <= n_dqoe;
      addr_q <= n_addr;
      dq_q   <= n_dq;
      wr_q   <= n_wr;
      col_q  <= n_col;
      wd_q   <= n_wd;
      rdv_q  <= cap;
      if (cap) rdd_q <= dram_dq_in;
    end
  end

  assign dram_ras_n  = ras_q;
  assign dram_cas_n  = cas_q;
  assign dram_we_n   = we_q;
  assign dram_oe_n   = oe_q;
  assign dram_addr   = addr_q;
  assign dram_dq_out = dq_q;
  assign dram_dq_oe  = dqoe_q;
  assign rd_valid    = rdv_q;
  assign rd_data     = rdd_q;
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RP      = 5,
  parameter int T_RC      = 14,
  parameter int T_RAS_MIN = 8,
  parameter int T_RCD     = 3,
  parameter int T_CP      = 2,
  parameter int T_RAS_MAX = 12500
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic ref_grant,
  input logic rd_valid,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe
);
  localparam int T_RAS_EFF = (T_RAS_MIN > T_RC - T_RP) ? T_RAS_MIN : T_RC - T_RP;

  int unsigned lo_cnt, hi_cnt, cas_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= 0;
      hi_cnt <= 0;
      cas_hi <= 0;
    end else begin
      lo_cnt <= dram_ras_n ? 0 : lo_cnt + 1;
      hi_cnt <= dram_ras_n ? hi_cnt + 1 : 0;
      cas_hi <= dram_cas_n ? cas_hi + 1 : 0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !rd_valid));

  a_r12_cas_in_row: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  a_r4_we_leads_cas: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0));

  a_r4_write_drive: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> (dram_oe_n && dram_dq_oe));

  a_r10_grant_blocks: assert property (@(posedge clk) disable iff (rst)
    ref_grant |-> !req_ready);

  a_r3_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r6_precharge: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (hi_cnt >= T_RP));

  a_r7_ras_min: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |-> (lo_cnt >= T_RAS_EFF));

  a_r8_ras_max: assert property (@(posedge clk) disable iff (rst)
    !dram_ras_n |-> (lo_cnt < T_RAS_MAX));

  a_r11_rcd: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> (lo_cnt >= T_RCD));

  a_r9_cas_high: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> (cas_hi >= T_CP));
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .T_RP(T_RP), .T_RC(T_RC), .T_RAS_MIN(T_RAS_MIN),
  .T_RCD(T_RCD), .T_CP(T_CP), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .ref_grant(ref_grant),
  .rd_valid(rd_valid), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;
  localparam int T_RP = 5, T_RC = 14, T_RAS_MIN = 8, T_RAH = 2, T_RCD = 3;
  localparam int T_CAS = 2, T_CAC = 2, T_RAC = 8, T_CP = 2, T_PC = 5;
  localparam int T_RAS_MAX = 300;
  localparam int T_RAS_EFF = (T_RAS_MIN > T_RC - T_RP) ? T_RAS_MIN : T_RC - T_RP;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, ref_grant = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0, dram_dq_in = '0;
  logic        req_ready, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [3:0]  rd_data, dram_dq_out;
  logic [10:0] dram_addr;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(
    .T_RP(T_RP), .T_RC(T_RC), .T_RAS_MIN(T_RAS_MIN), .T_RAH(T_RAH), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_CAC(T_CAC), .T_RAC(T_RAC), .T_CP(T_CP), .T_PC(T_PC),
    .T_RAS_MAX(T_RAS_MAX)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_grant(ref_grant),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  typedef struct { logic [21:0] a; bit wr; logic [3:0] d; } acc_t;
  acc_t       acc_q[$];
  logic [3:0] exp_q[$];
  logic [3:0] shadow[int];
  logic [3:0] model[int];

  int n_chk = 0, n_fail = 0, ras_falls = 0;
  int ras_lo = 0, ras_hi = 0, cas_lo = 0, cas_hi = 0, since_casf = 1000;
  bit prev_ras = 1, prev_cas = 1, prev_we = 1, prev_grant = 0;
  logic [10:0] row_l = '0, col_l = '0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // behavioural DRAM model and pin rule monitor, evaluated mid-cycle
  always @(negedge clk) begin
    if (rst) begin
      ras_lo = 0; ras_hi = 0; cas_lo = 0; cas_hi = 0;
      prev_ras = 1; prev_cas = 1; prev_we = 1;
    end else begin
      if (!dram_ras_n) begin
        ras_lo = prev_ras ? 1 : ras_lo + 1;
        if (prev_ras) begin
          ras_falls++;
          row_l = dram_addr;
          chk(ras_hi >= T_RP, "R6", "row precharge cycles", ras_hi, T_RP);
          chk(!prev_grant, "R10", "row opened under grant", 1, 0);
        end
        if (ras_lo > T_RAS_MAX) chk(0, "R8", "row low cycles", ras_lo, T_RAS_MAX);
        if (ras_lo == T_RAH && prev_ras == 0 && cas_lo == 0)
          ;
      end else begin
        if (!prev_ras) chk(ras_lo >= T_RAS_EFF, "R7", "row low cycles", ras_lo, T_RAS_EFF);
        ras_hi = prev_ras ? ras_hi + 1 : 1;
      end
      since_casf++;
      if (!dram_cas_n) begin
        if (dram_ras_n) chk(0, "R12", "column low with row high", 1, 0);
        cas_lo = prev_cas ? 1 : cas_lo + 1;
        if (prev_cas) begin
          acc_t e;
          col_l = dram_addr;
          chk(cas_hi >= T_CP, "R9", "column high cycles", cas_hi, T_CP);
          chk(since_casf >= T_PC, "R9", "column fall spacing", since_casf, T_PC);
          chk(ras_lo > T_RCD, "R11", "row-to-column cycles", ras_lo - 1, T_RCD);
          since_casf = 0;
          if (acc_q.size() == 0) chk(0, "R2", "unexpected column access", 1, 0);
          else begin
            e = acc_q.pop_front();
            chk({row_l, col_l} == e.a, "R2", "latched address", int'({row_l, col_l}), int'(e.a));
            chk(dram_we_n == !e.wr, "R4", "write enable level", dram_we_n, !e.wr);
            if (e.wr) begin
              chk(!prev_we, "R4", "write enable before column fall", prev_we, 0);
              chk(dram_dq_oe && dram_oe_n, "R4", "drive on, output enable high", {dram_dq_oe, dram_oe_n}, 3);
              chk(dram_dq_out == e.d, "R4", "write nibble", dram_dq_out, e.d);
              model[int'({row_l, col_l})] = dram_dq_out;
            end
          end
        end
        if (!dram_we_n && !dram_dq_oe) chk(0, "R4", "drive dropped during write", 0, 1);
      end else begin
        cas_hi = prev_cas ? cas_hi + 1 : 1;
        cas_lo = 0;
      end
      begin
        logic [3:0] v;
        v = model.exists(int'({row_l, col_l})) ? model[int'({row_l, col_l})] : 4'h0;
        dram_dq_in = (!dram_cas_n && dram_we_n && cas_lo >= T_CAC && ras_lo >= T_RAC) ? v : ~v;
      end
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R3", "unexpected read pulse", 1, 0);
        else begin
          logic [3:0] x;
          x = exp_q.pop_front();
          chk(rd_data == x, "R3", "read nibble", rd_data, x);
        end
      end
      prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n;
    end
    prev_grant = ref_grant;
  end

  task automatic wait_accept();
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic host_op(input bit wr, input logic [21:0] a, input logic [3:0] d);
    acc_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    e.a = a; e.wr = wr; e.d = d;
    acc_q.push_back(e);
    if (wr) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
    wait_accept();
  endtask

  task automatic drain();
    int n = 0;
    while ((acc_q.size() != 0 || exp_q.size() != 0) && n < 2000) begin @(negedge clk); n++; end
    chk(acc_q.size() == 0 && exp_q.size() == 0, "R3", "outstanding accesses", acc_q.size() + exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    // R1: reset state of the pins
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !rd_valid,
        "R1", "pins during reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid}, 6'b111100);
    rst = 1'b0;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && !dram_dq_oe && !rd_valid, "R1", "pins after reset", dram_ras_n, 1);

    // R2 R3 R4: single write then read back
    host_op(1, {11'd5, 11'd3}, 4'hA);
    host_op(0, {11'd5, 11'd3}, 4'h0);
    drain();

    // R5: a burst on one fresh row opens it only once
    f0 = ras_falls;
    for (int i = 0; i < 4; i++) host_op(1, {11'd77, 11'(i * 9)}, 4'(i + 3));
    for (int i = 0; i < 4; i++) host_op(0, {11'd77, 11'(i * 9)}, 4'h0);
    drain();
    chk(ras_falls - f0 == 1, "R5", "row openings for a same-row burst", ras_falls - f0, 1);

    // R6: alternating rows reopen every time
    f0 = ras_falls;
    for (int i = 0; i < 4; i++) host_op(i % 2, {11'(9 + i % 2), 11'd100}, 4'hC);
    drain();
    chk(ras_falls - f0 == 4, "R6", "row openings for alternating rows", ras_falls - f0, 4);

    // R2: address extremes
    host_op(1, 22'h3FFFFF, 4'h5);
    host_op(1, 22'h000000, 4'h9);
    host_op(0, 22'h3FFFFF, 4'h0);
    host_op(0, 22'h000000, 4'h0);
    drain();

    // R8: the row closes on its own with no traffic
    host_op(0, {11'd300, 11'd1}, 4'h0);
    drain();
    repeat (2 * T_RAS_MAX) @(negedge clk);
    chk(dram_ras_n == 1'b1, "R8", "row strobe after idle window", dram_ras_n, 1);

    // R8: a long stream of row hits still gets the row cycled
    f0 = ras_falls;
    for (int i = 0; i < 60; i++) host_op(i % 2 == 0, {11'd400, 11'(i / 2)}, 4'(i));
    drain();
    chk(ras_falls - f0 >= 2, "R8", "row openings during a long hit stream", ras_falls - f0, 2);

    // R10: refresh grant blocks requests and closes the row
    host_op(1, {11'd600, 11'd2}, 4'h6);
    @(negedge clk); ref_grant = 1'b1;
    repeat (30) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {11'd600, 11'd2};
    begin
      acc_t e;
      e.a = req_addr; e.wr = 0; e.d = 0;
      acc_q.push_back(e);
      exp_q.push_back(4'h6);
    end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      chk(!req_ready, "R10", "ready under grant", req_ready, 0);
    end
    chk(dram_ras_n == 1'b1, "R10", "row strobe under grant", dram_ras_n, 1);
    @(negedge clk); ref_grant = 1'b0;
    wait_accept();
    drain();

    finish_run();
  end
endmodule